// File: doc/BRIEF.md
# Parallel-Lane Block FIR Filter

This block filters one sample stream that arrives as a block of `L` consecutive samples on every clock. Lane 0 of a block is the earliest sample and lane `L-1` the latest. On every valid clock the block produces `L` filtered samples in the same lane order. All lanes are computed side by side at the block rate, and no faster clock is needed. Taps that reach back past the start of the current block read samples kept from earlier blocks. One stored block therefore stands for `L` sample periods of delay.

The coefficients are fixed when the design is built and supplied as a parameter array. When the coefficient list is a mirror image of itself, a parameter turns on a pre-adder. It sums the two samples that share a coefficient, so each such pair needs only one multiplier. By default the output is the full-precision sum. A non-zero shift parameter selects a narrower result that is rounded and saturated. The input and output are each qualified by a valid bit, and the pipeline latency is fixed.

Top module: `fir_block_lanes`

## Requirements
- R1: Output lane k of a valid block n equals y[L*n+k] = sum over i in 0..N-1 of COEF[i]*x[L*n+k-i], where the serial stream x is the concatenation of valid input blocks in lane order. Lane k sits at bits [k*W+W-1 : k*W] of its bus, where W is the lane width.
- R2: After reset the sample history is zero, so the first outputs equal the response to a stream that is zero before the first valid block.
- R3: `out_valid` is `in_valid` delayed by exactly 3 clock edges. A block captured at edge E appears on `out_data` after edge E+2.
- R4: Cycles with `in_valid` low leave the history unchanged. A gap between blocks has no effect on later results.
- R5: With SYM=1 and a mirrored coefficient list, the results are bit-identical to the direct form (SYM=0).
- R6: With SHIFT=0 and the default OW = DW+CW+clog2(N), each output lane is the exact sum in two's complement.
- R7: With SHIFT>0 each lane is (sum + 2^(SHIFT-1)) arithmetically shifted right by SHIFT, then saturated to the signed OW-bit range.
- R8: While `rst` is high, `out_valid` is 0 and `out_data` is 0 from the next edge on.
- R9: `out_data` keeps its previous value on every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_data` |
| in_data | input | L*DW | L signed samples, lane 0 earliest |
| out_valid | output | 1 | Qualifies `out_data` |
| out_data | output | L*OW | L signed filtered samples, lane order as input |

## Verification
A block driven before edge E is captured at E. It passes the window register at E, the product register at E+1 and the output register at E+2. The bench sets inputs at falling edges and reads the outputs at the third falling edge after it drove a block. A three-entry shift of driven valid bits gives the expected `out_valid` at each falling edge. Expected lane values come from a serial convolution over all valid samples seen since reset. They are queued when a block is driven and taken from the queue only when that shift register says the block is due, so gaps and resets stay aligned. On cycles when no block is due, the bench compares the outputs with the values seen one cycle earlier.

// File: rtl/fir_block_lanes.sv
module fir_block_lanes #(
  parameter int L     = 16,
  parameter int N     = 32,
  parameter int DW    = 12,
  parameter int CW    = 10,
  parameter bit SYM   = 1'b1,
  parameter int SHIFT = 0,
  parameter int OW    = DW + CW + $clog2(N),
  parameter int COEF [N] = '{3, -5, -9, 4, 17, 8, -22, -31, 6, 55, 48, -40, -110, -37, 190, 400,
                             400, 190, -37, -110, -40, 48, 55, 6, -31, -22, 8, 17, 4, -9, -5, 3}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [L*DW-1:0] in_data,
  output logic            out_valid,
  output logic [L*OW-1:0] out_data
);
  localparam int H    = (N + L - 2) / L;
  localparam int W    = (H + 1) * L;
  localparam int BASE = H * L;
  localparam int NP   = SYM ? (N + 1) / 2 : N;
  localparam int PW   = DW + CW + 1;
  localparam int AW   = DW + CW + $clog2(N);
  localparam int RS   = (SHIFT > 0) ? SHIFT - 1 : 0;
  localparam logic signed [AW:0] RND = (SHIFT > 0) ? ((AW+1)'(1) << RS) : '0;
  localparam logic signed [AW:0] HI  = (AW+1)'((64'sd1 <<< (OW - 1)) - 64'sd1);
  localparam logic signed [AW:0] LO  = -HI - (AW+1)'(1);

  logic [BASE*DW-1:0] hist;
  logic [W*DW-1:0]    win_q;
  logic [1:0]         vld;
  wire  [W*DW-1:0]    win_d = {in_data, hist};

  logic signed [PW-1:0] prod_d [L][NP];
  logic signed [PW-1:0] prod_q [L][NP];
  logic signed [AW-1:0] acc    [L];
  logic [L*OW-1:0]      res_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist      <= '0;
      vld       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (in_valid) hist <= win_d[W*DW-1:L*DW];
      vld       <= {vld[0], in_valid};
      out_valid <= vld[1];
    end
  end

  always_ff @(posedge clk) begin
    win_q  <= win_d;
    prod_q <= prod_d;
  end

  for (genvar k = 0; k < L; k++) begin : g_lane
    for (genvar p = 0; p < NP; p++) begin : g_tap
      localparam int JA = BASE + k - p;
      localparam int JB = BASE + k - (N - 1 - p);
      localparam logic signed [CW-1:0] C = CW'(COEF[p]);
      wire signed [DW-1:0] xa = win_q[JA*DW +: DW];
      if (SYM && (N - 1 - p != p)) begin : g_pair
        wire signed [DW-1:0] xb  = win_q[JB*DW +: DW];
        wire signed [DW:0]   pre = {xa[DW-1], xa} + {xb[DW-1], xb};
        assign prod_d[k][p] = pre * C;
      end else begin : g_single
        assign prod_d[k][p] = xa * C;
      end
    end

    wire signed [AW:0] ext = {acc[k][AW-1], acc[k]};
    wire signed [AW:0] rsh = (ext + RND) >>> SHIFT;
    assign res_d[k*OW +: OW] = (rsh > HI) ? OW'(HI) :
                               (rsh < LO) ? OW'(LO) : OW'(rsh);
  end

  always_comb begin
    for (int k = 0; k < L; k++) begin
      acc[k] = '0;
      for (int p = 0; p < NP; p++) acc[k] = acc[k] + AW'(prod_q[k][p]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         out_data <= '0;
    else if (vld[1]) out_data <= res_d;
  end
endmodule

module fir_block_lanes_chk #(
  parameter int L  = 16,
  parameter int OW = 27,
  parameter int HW = 384
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            out_valid,
  input logic [L*OW-1:0] out_data,
  input logic [HW-1:0]   hist
);
  p_latency_r3: assert property (@(posedge clk) disable iff (rst) in_valid |-> ##3 out_valid);
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst) !in_valid |-> ##3 !out_valid);
  p_gap_hold_r4: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(hist));
  p_hist_clear_r2: assert property (@(posedge clk) rst |=> hist == '0);
  p_reset_out_r8: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0));
  p_data_hold_r9: assert property (@(posedge clk) disable iff (rst) !out_valid |-> $stable(out_data));
endmodule

bind fir_block_lanes fir_block_lanes_chk #(.L(L), .OW(OW), .HW(H*L*DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data), .hist(hist)
);

// File: tb/tb_fir_block_lanes.sv
module tb_fir_block_lanes;
  localparam int L = 16, N = 32, DW = 12, CW = 10;
  localparam int OWF = DW + CW + $clog2(N);
  localparam int OWR = 10, SH = 8;
  localparam int CF [N] = '{3, -5, -9, 4, 17, 8, -22, -31, 6, 55, 48, -40, -110, -37, 190, 400,
                           400, 190, -37, -110, -40, 48, 55, 6, -31, -22, 8, 17, 4, -9, -5, 3};

  logic clk = 0, rst = 1, in_valid = 0;
  logic [L*DW-1:0]  in_data = '0;
  logic             ov_f, ov_r;
  logic [L*OWF-1:0] od_f, prev_f;
  logic [L*OWR-1:0] od_r, prev_r;

  always #10 clk = ~clk;

  fir_block_lanes #(.L(L), .N(N), .DW(DW), .CW(CW), .SYM(1'b1), .SHIFT(0), .OW(OWF), .COEF(CF)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .out_valid(ov_f), .out_data(od_f));
  fir_block_lanes #(.L(L), .N(N), .DW(DW), .CW(CW), .SYM(1'b0), .SHIFT(SH), .OW(OWR), .COEF(CF)) dut_rs (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .out_valid(ov_r), .out_data(od_r));

  int checks = 0, fails = 0;
  bit done = 0;
  longint xs[$];
  longint qf[$], qr[$];
  bit vq [3];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint satr(input longint a);
    longint r = (a + (64'sd1 <<< (SH - 1))) >>> SH;
    if (r > 511) return 511;
    if (r < -512) return -512;
    return r;
  endfunction

  task automatic model_push(input logic [L*DW-1:0] blk);
    for (int k = 0; k < L; k++) begin
      longint acc = 0;
      int m;
      xs.push_back(longint'($signed(blk[k*DW +: DW])));
      m = xs.size() - 1;
      for (int i = 0; i < N; i++) if (m - i >= 0) acc += CF[i] * xs[m-i];
      qf.push_back(acc);
      qr.push_back(satr(acc));
    end
  endtask

  task automatic cycle(input bit v, input logic [L*DW-1:0] blk);
    @(negedge clk);
    chk(ov_f == vq[2], "R3 full", ov_f, vq[2]);
    chk(ov_r == vq[2], "R3 rounded", ov_r, vq[2]);
    if (vq[2]) begin
      for (int k = 0; k < L; k++) begin
        longint ef = qf.pop_front();
        longint er = qr.pop_front();
        longint af = longint'($signed(od_f[k*OWF +: OWF]));
        longint ar = longint'($signed(od_r[k*OWR +: OWR]));
        chk(af == ef, "R1/R5/R6 lane", af, ef);
        chk(ar == er, "R7 lane", ar, er);
      end
    end else begin
      chk(od_f == prev_f, "R9 full hold", 0, 0);
      chk(od_r == prev_r, "R9 rounded hold", 0, 0);
    end
    prev_f = od_f;
    prev_r = od_r;
    in_valid = v;
    in_data  = blk;
    if (v) model_push(blk);
    vq[2] = vq[1]; vq[1] = vq[0]; vq[0] = v;
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 0; in_data = '0;
    repeat (3) begin
      @(negedge clk);
      chk(!ov_f && !ov_r, "R8 valid low", ov_f, 0);
      chk(od_f == '0 && od_r == '0, "R8 data zero", 0, 0);
    end
    rst = 0;
    xs.delete(); qf.delete(); qr.delete();
    vq = '{0, 0, 0};
    prev_f = '0; prev_r = '0;
  endtask

  function automatic logic [L*DW-1:0] rnd_blk();
    logic [L*DW-1:0] b;
    for (int k = 0; k < L; k++) b[k*DW +: DW] = DW'($urandom);
    return b;
  endfunction

  function automatic logic [L*DW-1:0] fill(input logic signed [DW-1:0] s);
    logic [L*DW-1:0] b;
    for (int k = 0; k < L; k++) b[k*DW +: DW] = s;
    return b;
  endfunction

  initial begin
    logic [L*DW-1:0] imp;
    do_reset();
    imp = '0;
    imp[5*DW +: DW] = DW'(1);
    cycle(1, imp);
    repeat (3) cycle(1, '0);
    imp = '0;
    imp[15*DW +: DW] = DW'(-2048);
    cycle(1, imp);
    repeat (3) cycle(1, '0);
    repeat (200) cycle(($urandom % 10) < 7, rnd_blk());
    repeat (4) cycle(0, '0);
    repeat (6) cycle(1, fill(12'sd2047));
    repeat (6) cycle(1, fill(-12'sd2048));
    cycle(1, rnd_blk());
    repeat (3) cycle(0, rnd_blk());
    do_reset();
    repeat (5) cycle(1, rnd_blk());
    repeat (300) cycle(($urandom % 4) != 0, rnd_blk());
    repeat (5) cycle(0, '0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule